// File: doc/BRIEF.md
# CCD Readout Clock Sequencer

This block produces the logic-level drive waveforms for an interline CCD whose vertical register is split into a top and a bottom half and whose charge leaves through up to four horizontal output registers. It builds four vertical phase patterns, two horizontal phase patterns and one output reset pattern. It routes them onto the device pins according to a readout mode chosen from quad, two dual variants and single output. Analog level shifting and fine edge placement are left to the clock drivers that follow it.

A frame begins with a one-cycle strobe while the sequencer is idle. The mode and the programmed line and pixel counts are captured at that strobe and raised to the mode's minimum when they are too small. Each line is then one vertical shift followed by a horizontal readout. The readout holds a few dummy slots and then the programmed number of real pixels. Line-valid covers every horizontal readout and pixel-valid marks each real pixel, so a capture path downstream can frame the digitised data.

Top module: `ccd_readout_sequencer`

## Requirements
- R1: After reset the sequencer is idle. Vertical phases 1 and 2 are high, so `vb` = 4'b0011 with bit i carrying phase i+1. The horizontal phases, line-valid and pixel-valid are low, and the captured mode is quad, so `vt` = 4'b0011 and `hrst` = 4'b0000.
- R2: A line shift takes 3 cycles and then returns to rest. Over those cycles `vb` reads 4'b0110, 4'b1100, 4'b1001 and then 4'b0011 again. Phase 1 falls on the first step, and on every change one phase rises in the same cycle that another falls. The vertical phases do not move during a horizontal readout.
- R3: The mode is encoded as 0 quad, 1 dual using outputs a and b, 2 dual using outputs a and c, and 3 single. In modes 0 and 2, top pin k carries phase k. In modes 1 and 3, the top pins 1 to 4 carry phases 1, 4, 3 and 2, which reverses the top shift direction.
- R4: The captured line count is raised to MIN_LINES_SHORT in modes 0 and 2, and to MIN_LINES_LONG in modes 1 and 3.
- R5: The captured pixel count is raised to MIN_PIX_SPLIT in modes 0 and 1, where the horizontal register is split, and to MIN_PIX_FULL in modes 2 and 3.
- R6: Each horizontal slot lasts 2 cycles. In the first cycle the first horizontal phase and the output reset of each used register are high. In the second cycle the second horizontal phase is high. A line holds DUMMY plus the pixel count slots.
- R7: Pixel-valid is high only in the second cycle of slots DUMMY and later, once for each captured pixel, and only while line-valid is high.
- R8: Output registers are indexed 0=a, 1=b, 2=c and 3=d. The used registers are all four in mode 0, a and b in mode 1, a and c in mode 2, and a alone in mode 3. The reset of an unused register is held high.
- R9: The mode and both counts are captured only by a frame strobe that arrives while the sequencer is idle. A strobe during a frame changes nothing.
- R10: A frame takes lines × (3 + 2 × (DUMMY + pixels)) active cycles, then returns to the idle state of R1 under the captured mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Readout mode select, captured at frame start |
| frame_start | input | 1 | One-cycle frame start strobe |
| line_count | input | LW | Requested lines per frame |
| pix_count | input | PW | Requested pixels per line |
| vt | output | 4 | Top vertical phase pins 1 to 4 |
| vb | output | 4 | Bottom vertical phase pins 1 to 4 |
| h1 | output | 4 | First horizontal phase, one bit per output register |
| h2 | output | 4 | Second horizontal phase, one bit per output register |
| hrst | output | 4 | Output reset, one bit per output register |
| line_valid | output | 1 | High during each horizontal readout |
| pix_valid | output | 1 | High for each real pixel |

## Verification
The assertions check on every cycle that vertical edges come in rising/falling pairs and that the phases stay still through a readout. They also check that the horizontal phases never overlap, that pixel-valid sits inside line-valid, that unused resets stay high and that the captured mode cannot change inside a frame. Only the bench scenarios can show the counting behaviour. That covers clamping to each mode's minimum, the number of dummy slots and pixels per line, the total frame length, the step order on the top pins for each mode, and that a strobe arriving mid-frame is ignored.

// File: rtl/ccd_readout_sequencer.sv
module ccd_readout_sequencer #(
  parameter int LW = 12,
  parameter int PW = 12,
  parameter int DUMMY = 11,
  parameter int MIN_LINES_SHORT = 1260,
  parameter int MIN_LINES_LONG = 2520,
  parameter int MIN_PIX_SPLIT = 1693,
  parameter int MIN_PIX_FULL = 3386
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          frame_start,
  input  logic [LW-1:0] line_count,
  input  logic [PW-1:0] pix_count,
  output logic [3:0]    vt,
  output logic [3:0]    vb,
  output logic [3:0]    h1,
  output logic [3:0]    h2,
  output logic [3:0]    hrst,
  output logic          line_valid,
  output logic          pix_valid
);
  localparam int SW = PW + 1;

  typedef enum logic [1:0] {S_IDLE, S_VSHIFT, S_HREAD} state_t;

  state_t        state;
  logic [1:0]    mode_q, vstep;
  logic [LW-1:0] lines_q, line_idx;
  logic [PW-1:0] pix_q;
  logic [SW-1:0] slot;
  logic          half;

  wire long_v = mode[0];
  wire full_h = mode[1];
  wire [LW-1:0] line_min = long_v ? LW'(MIN_LINES_LONG) : LW'(MIN_LINES_SHORT);
  wire [PW-1:0] pix_min  = full_h ? PW'(MIN_PIX_FULL) : PW'(MIN_PIX_SPLIT);
  wire [LW-1:0] lines_in = (line_count < line_min) ? line_min : line_count;
  wire [PW-1:0] pix_in   = (pix_count < pix_min) ? pix_min : pix_count;

  wire [SW-1:0] last_slot = SW'(DUMMY) + SW'(pix_q) - SW'(1);
  wire          last_line = (line_idx == lines_q - LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      mode_q   <= 2'd0;
      vstep    <= 2'd0;
      lines_q  <= '0;
      line_idx <= '0;
      pix_q    <= '0;
      slot     <= '0;
      half     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (frame_start) begin
          mode_q   <= mode;
          lines_q  <= lines_in;
          pix_q    <= pix_in;
          line_idx <= '0;
          vstep    <= 2'd1;
          state    <= S_VSHIFT;
        end
        S_VSHIFT: begin
          vstep <= vstep + 2'd1;
          if (vstep == 2'd3) begin
            state <= S_HREAD;
            slot  <= '0;
            half  <= 1'b0;
          end
        end
        S_HREAD: begin
          half <= ~half;
          if (half) begin
            if (slot == last_slot) begin
              if (last_line) state <= S_IDLE;
              else begin
                line_idx <= line_idx + LW'(1);
                vstep    <= 2'd1;
                state    <= S_VSHIFT;
              end
            end else slot <= slot + SW'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [3:0] pv;
  always_comb begin
    case (vstep)
      2'd0: pv = 4'b0011;
      2'd1: pv = 4'b0110;
      2'd2: pv = 4'b1100;
      default: pv = 4'b1001;
    endcase
  end

  logic [3:0] used;
  always_comb begin
    case (mode_q)
      2'd0: used = 4'b1111;
      2'd1: used = 4'b0011;
      2'd2: used = 4'b0101;
      default: used = 4'b0001;
    endcase
  end

  wire reading = (state == S_HREAD);
  wire p5 = reading & ~half;
  wire p6 = reading & half;

  assign vb = pv;
  assign vt = mode_q[0] ? {pv[1], pv[2], pv[3], pv[0]} : pv;
  assign h1 = {4{p5}};
  assign h2 = {4{p6}};
  assign hrst = ({4{p5}} & used) | ~used;
  assign line_valid = reading;
  assign pix_valid = p6 && (slot >= SW'(DUMMY));
endmodule

// File: rtl/ccd_readout_sequencer_chk.sv
module ccd_readout_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] vt,
  input logic [3:0] vb,
  input logic [3:0] h1,
  input logic [3:0] h2,
  input logic [3:0] hrst,
  input logic       line_valid,
  input logic       pix_valid,
  input logic [1:0] mode_q
);
  AST_V_EDGE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vb & ~$past(vb)) == $countones(~vb & $past(vb))); // R2
  AST_V_STILL_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && $past(line_valid)) |-> $stable(vb)); // R2
  AST_TOP_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[0] == 1'b0) |-> (vt == vb)); // R3
  AST_H_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(h1[0] && h2[0])); // R6
  AST_RST_WITH_H1: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> (hrst[0] == h1[0])); // R6
  AST_PIX_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (line_valid && h2[0])); // R7
  AST_UNUSED_RST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd3) |-> (hrst[3:1] == 3'b111)); // R8
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && $past(line_valid)) |-> $stable(mode_q)); // R9
endmodule

bind ccd_readout_sequencer ccd_readout_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vt(vt), .vb(vb), .h1(h1), .h2(h2),
  .hrst(hrst), .line_valid(line_valid), .pix_valid(pix_valid), .mode_q(mode_q)
);

// File: tb/ccd_readout_sequencer_test.sv
module ccd_readout_sequencer_test;
  localparam int D = 3;

  logic clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] line_count = 8'd0, pix_count = 8'd0;
  logic [3:0] vt, vb, h1, h2, hrst;
  logic line_valid, pix_valid;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ccd_readout_sequencer #(.LW(8), .PW(8), .DUMMY(D), .MIN_LINES_SHORT(3),
    .MIN_LINES_LONG(5), .MIN_PIX_SPLIT(4), .MIN_PIX_FULL(7)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .frame_start(frame_start),
    .line_count(line_count), .pix_count(pix_count), .vt(vt), .vb(vb),
    .h1(h1), .h2(h2), .hrst(hrst), .line_valid(line_valid), .pix_valid(pix_valid));

  // mode, line_count, pix_count, expected lines, expected pixels
  localparam logic [33:0] VEC [0:6] = '{
    {2'd0, 8'd4, 8'd5, 8'd4, 8'd5},
    {2'd0, 8'd1, 8'd1, 8'd3, 8'd4},
    {2'd1, 8'd3, 8'd2, 8'd5, 8'd4},
    {2'd2, 8'd2, 8'd9, 8'd3, 8'd9},
    {2'd2, 8'd3, 8'd7, 8'd3, 8'd7},
    {2'd3, 8'd6, 8'd3, 8'd6, 8'd7},
    {2'd3, 8'd0, 8'd0, 8'd5, 8'd7}};
  localparam logic [3:0] UNUSED [0:3] = '{4'b0000, 4'b1100, 4'b1010, 4'b1110};
  localparam logic [3:0] VT_IDLE [0:3] = '{4'b0011, 4'b1001, 4'b0011, 4'b1001};
  localparam logic [3:0] VB_SEQ [0:3] = '{4'b0110, 4'b1100, 4'b1001, 4'b0011};
  localparam logic [3:0] VT_REV [0:3] = '{4'b1100, 4'b0110, 4'b0011, 4'b1001};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [1:0] m, input logic [7:0] lc, input logic [7:0] pc,
                           input bit interfere, input int el, input int ep);
    int n_lines = 0, n_pix = 0, n_act = 0, n_dummy = 0, n_rst = 0, n_bad = 0;
    int vb_ok = 1, vt_ok = 1;
    logic prev_lv = 1'b0;
    @(negedge clk);
    mode = m; line_count = lc; pix_count = pc; frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    for (int k = 0; k < 200; k++) begin
      if (k < 4) begin
        if (vb != VB_SEQ[k]) vb_ok = 0;
        if (vt != (m[0] ? VT_REV[k] : VB_SEQ[k])) vt_ok = 0;
      end
      if (line_valid && !prev_lv) n_lines++;
      prev_lv = line_valid;
      if (pix_valid) n_pix++;
      if (line_valid || vb != 4'b0011) n_act++;
      if (h2[0] && !pix_valid) n_dummy++;
      if (line_valid && hrst[0]) n_rst++;
      if ((hrst & UNUSED[m]) != UNUSED[m]) n_bad++;
      if (interfere && k == 20) begin
        mode = ~m; line_count = 8'd20; pix_count = 8'd20;
      end
      frame_start = interfere && (k == 20);
      @(negedge clk);
    end
    frame_start = 1'b0;
    chk("R4 lines", n_lines, el);
    chk("R5/R7 pixels", n_pix, el * ep);
    chk("R10 active cycles", n_act, el * (3 + 2 * (D + ep)));
    chk("R6/R7 dummy slots", n_dummy, el * D);
    chk("R6 reset pulses", n_rst, el * (D + ep));
    chk("R8 unused reset high", n_bad, 0);
    chk("R2 vertical steps", vb_ok, 1);
    chk("R3 top pin steps", vt_ok, 1);
    chk("R10/R9 idle top pins", int'(vt), int'(VT_IDLE[m]));
    chk("R10 idle line_valid", int'(line_valid), 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 vb", int'(vb), 4'b0011);
    chk("R1 vt", int'(vt), 4'b0011);
    chk("R1 h1/h2", int'({h1, h2}), 0);
    chk("R1 hrst", int'(hrst), 0);
    chk("R1 valids", int'({line_valid, pix_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", int'(vb), 4'b0011);
    for (int i = 0; i < 7; i++)
      run_frame(VEC[i][33:32], VEC[i][31:24], VEC[i][23:16], 1'b0,
                int'(VEC[i][15:8]), int'(VEC[i][7:0]));
    // R9: strobe and new settings during a quad frame are ignored
    run_frame(2'd0, 8'd4, 8'd5, 1'b1, 4, 5);
    // R9: a strobe from idle afterwards captures the new settings
    run_frame(2'd3, 8'd5, 8'd7, 1'b0, 5, 7);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule